// File: doc/BRIEF.md
# Indirect-Access Ethernet Controller Register File

This block is the host-visible register file of an Ethernet controller. The host sees only two 16-bit locations. The first is an index port, which selects one of the internal registers. The second is a window port, which reads or writes the selected register. The index stays where it was written, so software can select the command/status register once and then work only through the window.

The command/status register (index 0) mixes three kinds of bits:
- command bits that are set by writing a one and turn into one-cycle pulses toward the transmit, receive and init engines;
- sticky event flags that the engines raise and that software clears by writing a one;
- read-only run state and summary bits.

The other registers hold:
- the init-block address (indices 1 and 2);
- a bus/byte-order control word (index 3), which a stop command wipes;
- four multicast filter words (indices 8 to 11);
- a mode word (index 15), whose top bit enables promiscuous reception.

Top module: `ctrl_csr_file`

## Requirements
- R1: A write to the index port (host_port_sel=1) stores host_wdata[3:0] as the index, and a read of the index port returns it zero-extended. Every window access (host_port_sel=0) goes to the register that index selects, and the index persists across accesses.
- R2: In register 0, writing a one to bit 0 (init) or bit 3 (transmit demand) gives a one-cycle pulse on cmd_init or cmd_tdemand in the cycle after the write, and neither bit ever reads back as one. After writing 0x0005, register 0 reads exactly 0x0004.
- R3: Bits 8..14 of register 0 are sticky event flags:
  - bit 8 is init done, bit 9 is transmit done, bit 10 is receive done;
  - bit 11 is memory error, bit 12 is missed frame, bit 13 is carrier error, bit 14 is babble.
  
  An engine event input sets its flag. Writing a one clears the flag and writing a zero leaves it unchanged. An event in the same cycle as the clearing write wins.
- R4: Bit 15 of register 0 reads as the OR of bits 11..14. Bit 7 reads as the OR of bits 8, 9, 10 and 15.
- R5: Bit 6 of register 0 (interrupt enable) is plain read/write. The irq output is high exactly while bits 7 and 6 are both one.
- R6: Writing a one to bit 2 (stop) of register 0 has these effects, and it overrides init and start written in the same word:
  - it clears bits 1, 4 and 5;
  - it sets bit 2;
  - it clears register 3 to zero;
  - it pulses cmd_stop and suppresses cmd_init and cmd_start.
- R7: Writing a one to bit 1 (start) without stop has effect only if bit 8 is already set. It then sets bits 1 (start), 4 (transmit on) and 5 (receive on), clears bit 2 and pulses cmd_start. Otherwise it changes nothing and gives no pulse. An init write without stop also clears bit 2.
- R8: Bits 4, 5, 7 and 15 of register 0 are read-only: writes to them have no effect.
- R9: Registers 1, 2, 8..11 and 15 are 16-bit read/write and drive init_addr_lo, init_addr_hi, mcast_filter (word k in bits 16k+15:16k) and promisc (register 15 bit 15). Register 3 keeps only bits 2:0 and drives bus_ctl.
- R10: After reset, register 0 reads 0x0004 and every other register reads 0. Indices with no register read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_port_sel | input | 1 | 1 selects the index port, 0 the data window |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected port |
| ev_init_done | input | 1 | Init engine finished |
| ev_tx_done | input | 1 | Transmit completed |
| ev_rx_done | input | 1 | Receive completed |
| ev_mem_err | input | 1 | Memory access error |
| ev_missed | input | 1 | Frame missed |
| ev_babble | input | 1 | Transmit overran length |
| ev_carrier | input | 1 | Carrier error |
| cmd_init | output | 1 | Init command pulse |
| cmd_start | output | 1 | Start command pulse |
| cmd_stop | output | 1 | Stop command pulse |
| cmd_tdemand | output | 1 | Transmit demand pulse |
| irq | output | 1 | Interrupt request |
| init_addr_lo | output | 16 | Init block address, low word |
| init_addr_hi | output | 16 | Init block address, high word |
| bus_ctl | output | 3 | Bus and byte-order control |
| mcast_filter | output | 64 | Multicast filter words |
| promisc | output | 1 | Promiscuous reception enable |

## Verification
The hardest state to reach from the ports is an engine event that lands in the same cycle as a write-one-to-clear of the same flag. The bench raises the transmit-done input at the negative edge where it also drives the clearing write, so both reach one rising edge together. The stop-over-start priority only matters while the block is running. The stimulus therefore first raises init done, accepts a start, and then writes stop and start in one word.

// File: rtl/ctrl_csr_pkg.sv
package ctrl_csr_pkg;
  localparam int unsigned CSR_W     = 16;
  localparam int unsigned EV_N      = 7;
  localparam int unsigned IDX_INIT_LO = 1;
  localparam int unsigned IDX_INIT_HI = 2;
  localparam int unsigned IDX_BUS     = 3;
  localparam int unsigned IDX_MC_BASE = 8;
  localparam int unsigned IDX_MODE    = 15;

  // error summary over memory error, missed, carrier, babble
  function automatic logic err_of(input logic [3:0] errs);
    return |errs;
  endfunction

  function automatic logic intr_of(input logic idon, input logic tint,
                                   input logic rint, input logic err);
    return idon | tint | rint | err;
  endfunction
endpackage

// File: rtl/ctrl_csr0.sv
module ctrl_csr0
  import ctrl_csr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [CSR_W-1:0]     wdata,
  input  logic [EV_N-1:0]      ev_vec,
  output logic [CSR_W-1:0]     rdata,
  output logic                 inea,
  output logic                 intr,
  output logic                 stop_req,
  output logic                 cmd_init,
  output logic                 cmd_start,
  output logic                 cmd_stop,
  output logic                 cmd_tdemand
);
  logic [EV_N-1:0] sticky_q;
  logic            stopped_q, strt_q, txon_q, rxon_q, inea_q;
  logic            init_req, strt_req, start_ok, tdmd_req, err;
  logic [EV_N-1:0] clr_vec;

  assign stop_req = wr & wdata[2];
  assign init_req = wr & wdata[0] & ~wdata[2];
  assign strt_req = wr & wdata[1] & ~wdata[2];
  assign start_ok = strt_req & sticky_q[0];
  assign tdmd_req = wr & wdata[3];
  assign clr_vec  = wr ? wdata[14:8] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q  <= '0;
      stopped_q <= 1'b1;
      strt_q    <= 1'b0;
      txon_q    <= 1'b0;
      rxon_q    <= 1'b0;
      inea_q    <= 1'b0;
      cmd_init  <= 1'b0;
      cmd_start <= 1'b0;
      cmd_stop  <= 1'b0;
      cmd_tdemand <= 1'b0;
    end else begin
      sticky_q <= ev_vec | (sticky_q & ~clr_vec);
      if (wr) inea_q <= wdata[6];
      if (stop_req) begin
        stopped_q <= 1'b1;
        strt_q <= 1'b0;
        txon_q <= 1'b0;
        rxon_q <= 1'b0;
      end else begin
        if (init_req || start_ok) stopped_q <= 1'b0;
        if (start_ok) begin
          strt_q <= 1'b1;
          txon_q <= 1'b1;
          rxon_q <= 1'b1;
        end
      end
      cmd_init    <= init_req;
      cmd_start   <= start_ok;
      cmd_stop    <= stop_req;
      cmd_tdemand <= tdmd_req;
    end
  end

  assign err   = err_of(sticky_q[6:3]);
  assign intr  = intr_of(sticky_q[0], sticky_q[1], sticky_q[2], err);
  assign inea  = inea_q;
  assign rdata = {err, sticky_q, intr, inea_q, rxon_q, txon_q, 1'b0,
                  stopped_q, strt_q, 1'b0};

  logic unused_ok;
  assign unused_ok = ^{wdata[15], wdata[7], wdata[5:4]};

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!txon_q && !rxon_q && !strt_q && stopped_q)); // R6
  AST_STOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |-> (!cmd_init && !cmd_start)); // R6
  AST_STRT_NEEDS_IDON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txon_q) |-> $past(sticky_q[0])); // R7
  AST_W1C_TINT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[9] && !ev_vec[1]) |=> !sticky_q[1]); // R3
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[1] |=> sticky_q[1]); // R3
endmodule

// File: rtl/ctrl_cfg_regs.sv
module ctrl_cfg_regs
  import ctrl_csr_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned MC_WORDS = 4,
  parameter int unsigned BUS_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [IDX_W-1:0]          idx,
  input  logic [CSR_W-1:0]          wdata,
  input  logic                      stop_clr,
  output logic [CSR_W-1:0]          rdata,
  output logic [CSR_W-1:0]          init_lo,
  output logic [CSR_W-1:0]          init_hi,
  output logic [BUS_W-1:0]          bus_ctl,
  output logic [MC_WORDS*CSR_W-1:0] mcast,
  output logic [CSR_W-1:0]          mode
);
  logic [CSR_W-1:0] mc_q [MC_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_lo <= '0;
      init_hi <= '0;
      bus_ctl <= '0;
      mode    <= '0;
    end else begin
      if (wr && idx == IDX_W'(IDX_INIT_LO)) init_lo <= wdata;
      if (wr && idx == IDX_W'(IDX_INIT_HI)) init_hi <= wdata;
      if (wr && idx == IDX_W'(IDX_MODE))    mode    <= wdata;
      if (stop_clr) bus_ctl <= '0;
      else if (wr && idx == IDX_W'(IDX_BUS)) bus_ctl <= wdata[BUS_W-1:0];
    end
  end

  for (genvar g = 0; g < MC_WORDS; g++) begin : g_mc
    always_ff @(posedge clk) begin
      if (!rst_n) mc_q[g] <= '0;
      else if (wr && idx == IDX_W'(IDX_MC_BASE + g)) mc_q[g] <= wdata;
    end
    assign mcast[g*CSR_W +: CSR_W] = mc_q[g];
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_W'(IDX_INIT_LO)) rdata = init_lo;
    if (idx == IDX_W'(IDX_INIT_HI)) rdata = init_hi;
    if (idx == IDX_W'(IDX_BUS))     rdata = CSR_W'(bus_ctl);
    if (idx == IDX_W'(IDX_MODE))    rdata = mode;
    for (int i = 0; i < MC_WORDS; i++)
      if (idx == IDX_W'(IDX_MC_BASE + i)) rdata = mc_q[i];
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !stop_clr) |=> $stable(bus_ctl)); // R9
endmodule

// File: rtl/ctrl_csr_file.sv
module ctrl_csr_file
  import ctrl_csr_pkg::*;
#(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned MC_WORDS = 4,
  parameter int unsigned BUS_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_port_sel,
  input  logic                      host_wr,
  input  logic [15:0]               host_wdata,
  output logic [15:0]               host_rdata,
  input  logic                      ev_init_done,
  input  logic                      ev_tx_done,
  input  logic                      ev_rx_done,
  input  logic                      ev_mem_err,
  input  logic                      ev_missed,
  input  logic                      ev_babble,
  input  logic                      ev_carrier,
  output logic                      cmd_init,
  output logic                      cmd_start,
  output logic                      cmd_stop,
  output logic                      cmd_tdemand,
  output logic                      irq,
  output logic [15:0]               init_addr_lo,
  output logic [15:0]               init_addr_hi,
  output logic [BUS_W-1:0]          bus_ctl,
  output logic [MC_WORDS*16-1:0]    mcast_filter,
  output logic                      promisc
);
  logic [IDX_W-1:0] idx_q;
  logic             win_wr, csr0_wr, stop_req, inea, intr;
  logic [CSR_W-1:0] csr0_rd, cfg_rd, mode;
  logic [EV_N-1:0]  ev_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (host_wr && host_port_sel) idx_q <= host_wdata[IDX_W-1:0];
  end

  assign win_wr  = host_wr & ~host_port_sel;
  assign csr0_wr = win_wr & (idx_q == '0);
  assign ev_vec  = {ev_babble, ev_carrier, ev_missed, ev_mem_err,
                    ev_rx_done, ev_tx_done, ev_init_done};

  ctrl_csr0 u_csr0 (
    .clk(clk), .rst_n(rst_n), .wr(csr0_wr), .wdata(host_wdata),
    .ev_vec(ev_vec), .rdata(csr0_rd), .inea(inea), .intr(intr),
    .stop_req(stop_req), .cmd_init(cmd_init), .cmd_start(cmd_start),
    .cmd_stop(cmd_stop), .cmd_tdemand(cmd_tdemand)
  );

  ctrl_cfg_regs #(.IDX_W(IDX_W), .MC_WORDS(MC_WORDS), .BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(win_wr), .idx(idx_q), .wdata(host_wdata),
    .stop_clr(stop_req), .rdata(cfg_rd), .init_lo(init_addr_lo),
    .init_hi(init_addr_hi), .bus_ctl(bus_ctl), .mcast(mcast_filter),
    .mode(mode)
  );

  assign irq        = intr & inea;
  assign promisc    = mode[15];
  assign host_rdata = host_port_sel ? CSR_W'(idx_q)
                    : (idx_q == '0) ? csr0_rd : cfg_rd;

  AST_STOP_CLEARS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (bus_ctl == '0)); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_port_sel) |=> $stable(idx_q)); // R1
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr0_rd[6] && csr0_rd[7]); // R5
endmodule

// File: tb/tb_ctrl_csr_file.sv
module tb_ctrl_csr_file;
  logic clk = 0, rst_n = 0;
  logic host_port_sel = 0, host_wr = 0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic ev_init_done = 0, ev_tx_done = 0, ev_rx_done = 0, ev_mem_err = 0;
  logic ev_missed = 0, ev_babble = 0, ev_carrier = 0;
  logic cmd_init, cmd_start, cmd_stop, cmd_tdemand, irq, promisc;
  logic [15:0] init_addr_lo, init_addr_hi;
  logic [2:0]  bus_ctl;
  logic [63:0] mcast_filter;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ctrl_csr_file dut (.*);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] v);
    @(negedge clk);
    host_port_sel = sel; host_wr = 1; host_wdata = v;
    @(negedge clk);
    host_wr = 0; host_port_sel = 0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    host_port_sel = sel; #1; v = host_rdata; host_port_sel = 0; #1;
  endtask

  task automatic pulse_ev(input logic [6:0] m);
    @(negedge clk);
    {ev_babble, ev_carrier, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = m;
    @(negedge clk);
    {ev_babble, ev_carrier, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = '0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(0, v); chk("R10 csr0 reset", v, 16'h0004);
    rd(1, v); chk("R10 index reset", v, 0);
    chk("R10 irq reset", irq, 0);
    chk("R10 bus reset", bus_ctl, 0);
  endtask

  task automatic t_cfg();
    logic [15:0] v;
    wr(1, 16'd1); wr(0, 16'h1234);
    rd(0, v); chk("R1 csr1 readback", v, 16'h1234);
    rd(0, v); chk("R1 index persists", v, 16'h1234);
    rd(1, v); chk("R1 index port", v, 16'd1);
    chk("R9 init_addr_lo", init_addr_lo, 16'h1234);
    wr(1, 16'd2); wr(0, 16'hBEEF); chk("R9 init_addr_hi", init_addr_hi, 16'hBEEF);
    wr(1, 16'd3); wr(0, 16'hFFFF);
    rd(0, v); chk("R9 csr3 width", v, 16'h0007);
    chk("R9 bus_ctl", bus_ctl, 3'd7);
    for (int i = 0; i < 4; i++) begin
      wr(1, 16'(8 + i)); wr(0, 16'hA000 + 16'(i));
    end
    chk("R9 mcast", mcast_filter, 64'hA003_A002_A001_A000);
    wr(1, 16'd15); wr(0, 16'h8000); chk("R9 promisc", promisc, 1);
    wr(1, 16'd5); wr(0, 16'hFFFF);
    rd(0, v); chk("R10 hole reads 0", v, 0);
    wr(1, 16'd1); rd(0, v); chk("R10 hole write ignored", v, 16'h1234);
  endtask

  task automatic t_cmds();
    logic [15:0] v;
    wr(1, 16'd0);
    wr(0, 16'h0005);
    chk("R6 stop pulse", cmd_stop, 1); chk("R6 init suppressed", cmd_init, 0);
    rd(0, v); chk("R2 init|stop reads stop", v, 16'h0004);
    chk("R6 csr3 cleared", bus_ctl, 0);
    wr(0, 16'h0001);
    chk("R2 init pulse", cmd_init, 1);
    rd(0, v); chk("R2 init not read back", v, 16'h0000);
    @(negedge clk); chk("R2 init one cycle", cmd_init, 0);
    wr(0, 16'h0008);
    chk("R2 tdemand pulse", cmd_tdemand, 1);
    rd(0, v); chk("R2 tdmd not read back", v, 0);
    wr(0, 16'h0002);
    chk("R7 start ignored", cmd_start, 0);
    rd(0, v); chk("R7 no idon no run", v, 0);
  endtask

  task automatic t_run();
    logic [15:0] v;
    pulse_ev(7'b0000001);
    rd(0, v); chk("R3 idon set", v, 16'h0180);
    chk("R5 irq masked", irq, 0);
    wr(0, 16'h0040);
    rd(0, v); chk("R5 inea rw", v, 16'h01C0);
    chk("R5 irq on", irq, 1);
    wr(0, 16'h0042);
    chk("R7 start pulse", cmd_start, 1);
    rd(0, v); chk("R7 running", v, 16'h01F2);
    wr(0, 16'h80F2);
    rd(0, v); chk("R8 read-only bits", v, 16'h01F2);
    wr(0, 16'h0140);
    rd(0, v); chk("R3 w1c idon", v, 16'h0072);
    chk("R5 irq off", irq, 0);
    wr(0, 16'h0040);
    rd(0, v); chk("R3 write zero no effect", v, 16'h0072);
  endtask

  task automatic t_errs();
    logic [15:0] v;
    pulse_ev(7'b1000000);
    rd(0, v); chk("R4 babble summary", v, 16'hC0F2);
    chk("R4 irq from err", irq, 1);
    pulse_ev(7'b0001000);
    rd(0, v); chk("R4 merr", v, 16'hC8F2);
    wr(0, 16'h4040);
    rd(0, v); chk("R4 err held by merr", v, 16'h88F2);
    wr(0, 16'h0840);
    rd(0, v); chk("R4 err clear", v, 16'h0072);
    pulse_ev(7'b0000010);
    @(negedge clk);
    ev_tx_done = 1; host_wr = 1; host_wdata = 16'h0240;
    @(negedge clk);
    ev_tx_done = 0; host_wr = 0;
    rd(0, v); chk("R3 event beats clear", v, 16'h02F2);
    wr(1, 16'd3); wr(0, 16'h0004); wr(1, 16'd0);
    wr(0, 16'h0046);
    chk("R6 stop over start", cmd_start, 0);
    chk("R6 stop pulse run", cmd_stop, 1);
    rd(0, v); chk("R6 stopped state", v, 16'h02C4);
    chk("R6 bswp cleared", bus_ctl, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset(); t_cfg(); t_cmds(); t_run(); t_errs();
      end
      begin
        repeat (20000) @(negedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule